// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds recently used virtual-to-physical page translations so that most memory accesses skip a page table walk. A lookup presents a virtual page number together with the identifier of the running address space. One cycle later the block answers with hit or miss, and on a hit it also gives the physical frame number and the access permission bits. On a miss the surrounding logic walks the page tables and then installs the result through the refill port.

Storage has two parts that are searched in parallel. The main part has 64 entries in a two-way set-associative array of 32 sets. A single pseudo-LRU bit per set picks the refill victim. The second part is a small fully associative pinned region. Only explicit pinned writes load it, and refills never replace its entries. Each entry carries an address-space identifier and a global flag, so a context switch does not need a full invalidation. The maintenance port can invalidate the whole main array, or only the non-global entries of one identifier.

Top module: `asid_tlb`

## Requirements
- R1: Every lookup request sampled at a rising edge gives `rsp_valid` high for exactly the cycle after that edge, with `rsp_hit`, `rsp_pfn` and `rsp_perm`. On a miss, `rsp_pfn` and `rsp_perm` are zero. Without a request, `rsp_valid` is low.
- R2: A non-global entry hits only when the whole virtual page number and the 8-bit identifier both match the lookup.
- R3: An entry with its global flag set hits for any lookup identifier.
- R4: In the main array the set index is VPN bits [4:0] and the tag is the remaining upper bits. Two translations with the same index and different tags are held at the same time, one in each way.
- R5: A refill picks way 0 if it is invalid, else way 1 if it is invalid, else the least recently used way of the set. A lookup hit in the main array and a refill each make the touched way the most recently used.
- R6: The pinned region has 8 slots, each written only through the pinned write port at the given slot number. Its entries follow the same identifier and global rules as R2 and R3, compare the whole page number, and are never replaced by refills.
- R7: When a pinned entry and a main entry both hit, the frame and permissions come from the pinned entry.
- R8: A full flush invalidates every main-array entry in one cycle. Pinned entries are untouched.
- R9: A flush by identifier invalidates only the main-array entries that are non-global and whose identifier equals the given one. Global entries, entries of other identifiers and pinned entries still hit.
- R10: A lookup sampled in the same cycle as either kind of flush returns a miss.
- R11: The 2-bit permission field stored with an entry is returned unchanged on a hit. Bit 1 set means user-mode access is allowed, and bit 0 set means writes are allowed.
- R12: After a synchronous active-low reset, every entry is invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Identifier of the running address space |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | 20 | Physical frame number on hit |
| rsp_perm | output | 2 | Permission bits on hit (bit 1 user, bit 0 write) |
| rf_valid | input | 1 | Install a translation in the main array |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_asid | input | 8 | Refill identifier |
| rf_global | input | 1 | Refill entry is global |
| rf_pfn | input | 20 | Refill frame number |
| rf_perm | input | 2 | Refill permission bits |
| pw_valid | input | 1 | Write a pinned slot |
| pw_slot | input | 3 | Pinned slot number |
| pw_vpn | input | 20 | Pinned virtual page number |
| pw_asid | input | 8 | Pinned identifier |
| pw_global | input | 1 | Pinned entry is global |
| pw_pfn | input | 20 | Pinned frame number |
| pw_perm | input | 2 | Pinned permission bits |
| fl_all | input | 1 | Invalidate all main-array entries |
| fl_asid_en | input | 1 | Invalidate the main-array entries of one identifier |
| fl_asid | input | 8 | Identifier for the selective flush |

## Verification
The assertions assume that software never installs a translation that is already present. Under that assumption at most one main way and at most one pinned slot match any lookup, and the exclusivity checks rely on it. The checks also assume that a refill never falls in the same cycle as a flush or as a lookup to the same set. The stimulus keeps within these limits: every installed page number and identifier pair is different from those already present, and each refill, pinned write and flush runs in a cycle of its own. The only deliberate overlap is a lookup issued together with a full flush, which is the case the flush-miss rule covers.

// File: rtl/tlb_pkg.sv
// Shared constants and types for the address-space-tagged translation cache.
// Assumes a fixed associativity of two for the main array (one LRU bit per set).
package tlb_pkg;
    localparam int PERM_W = 2;
    localparam int WAYS   = 2;
    localparam int PERM_USER_BIT  = 1;
    localparam int PERM_WRITE_BIT = 0;
    typedef logic [PERM_W-1:0] tlb_perm_t;
endpackage

// File: rtl/tlb_way.sv
// One way of the main array: per-set valid, tag, identifier, global flag,
// frame and permissions, with a combinational match for the lookup index.
// Assumes a refill never shares a cycle with a full flush (the flush wins).
module tlb_way
    import tlb_pkg::*;
#(
    parameter int SETS   = 32,
    parameter int TAG_W  = 15,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ASID_W-1:0] rd_asid,
    output logic              rd_hit,
    output logic [PFN_W-1:0]  rd_pfn,
    output tlb_perm_t         rd_perm,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  tlb_perm_t         wr_perm,
    input  logic              fl_all,
    input  logic              fl_asid_en,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [IDX_W-1:0]  probe_idx,
    output logic              probe_valid
);
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   glob_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [ASID_W-1:0] asid_q [SETS];
    logic [PFN_W-1:0]  pfn_q  [SETS];
    tlb_perm_t         perm_q [SETS];

    // Valid bits: reset, flush-all, selective flush, then refill set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fl_all) begin
            valid_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (fl_asid_en && !glob_q[s] && asid_q[s] == fl_asid)
                    valid_q[s] <= 1'b0;
            end
            if (wr_en)
                valid_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload storage, written on refill only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            glob_q[wr_idx] <= wr_glob;
            tag_q[wr_idx]  <= wr_tag;
            asid_q[wr_idx] <= wr_asid;
            pfn_q[wr_idx]  <= wr_pfn;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    // Match of the indexed entry against tag and identifier.
    always_comb begin
        rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag)
                  && (glob_q[rd_idx] || asid_q[rd_idx] == rd_asid);
        rd_pfn  = pfn_q[rd_idx];
        rd_perm = perm_q[rd_idx];
    end

    assign probe_valid = valid_q[probe_idx];

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (valid_q == '0));
endmodule

// File: rtl/tlb_lock_region.sv
// Fully associative pinned region: slots loaded only by explicit writes,
// searched on the whole page number, lowest matching slot reported.
// Assumes software keeps pinned translations unique.
module tlb_lock_region
    import tlb_pkg::*;
#(
    parameter int LOCK_N = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    localparam int SLOT_W = $clog2(LOCK_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  rd_vpn,
    input  logic [ASID_W-1:0] rd_asid,
    output logic              rd_hit,
    output logic [PFN_W-1:0]  rd_pfn,
    output tlb_perm_t         rd_perm,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  tlb_perm_t         wr_perm
);
    logic [LOCK_N-1:0] valid_q;
    logic [LOCK_N-1:0] glob_q;
    logic [VPN_W-1:0]  vpn_q  [LOCK_N];
    logic [ASID_W-1:0] asid_q [LOCK_N];
    logic [PFN_W-1:0]  pfn_q  [LOCK_N];
    tlb_perm_t         perm_q [LOCK_N];
    logic [LOCK_N-1:0] match;

    // Slot valid bits: cleared by reset, set by a pinned write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_slot] <= 1'b1;
    end

    // Slot payload storage.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            glob_q[wr_slot] <= wr_glob;
            vpn_q[wr_slot]  <= wr_vpn;
            asid_q[wr_slot] <= wr_asid;
            pfn_q[wr_slot]  <= wr_pfn;
            perm_q[wr_slot] <= wr_perm;
        end
    end

    // Per-slot compare.
    generate
        for (genvar i = 0; i < LOCK_N; i++) begin : g_cmp
            assign match[i] = valid_q[i] && (vpn_q[i] == rd_vpn)
                              && (glob_q[i] || asid_q[i] == rd_asid);
        end
    endgenerate

    // Select the lowest matching slot.
    always_comb begin
        rd_hit  = 1'b0;
        rd_pfn  = '0;
        rd_perm = '0;
        for (int i = LOCK_N - 1; i >= 0; i--) begin
            if (match[i]) begin
                rd_hit  = 1'b1;
                rd_pfn  = pfn_q[i];
                rd_perm = perm_q[i];
            end
        end
    end

    assert_lock_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_victim_sel.sv
// Per-set pseudo-LRU bit and refill way choice for a two-way array.
// The LRU bit names the way to replace next; an invalid way is preferred.
module tlb_victim_sel #(
    parameter int SETS = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_v0,
    input  logic             fill_v1,
    output logic             victim
);
    logic [SETS-1:0] lru_q;

    // Choose the refill way: invalid first, else the least recent one.
    always_comb begin
        if (!fill_v0)
            victim = 1'b0;
        else if (!fill_v1)
            victim = 1'b1;
        else
            victim = lru_q[fill_idx];
    end

    // Point the LRU bit away from the way just used; refill updates last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (touch_en)
                lru_q[touch_idx] <= ~touch_way;
            if (fill_en)
                lru_q[fill_idx] <= ~victim;
        end
    end
endmodule

// File: rtl/asid_tlb.sv
// Translation cache top: two main-array ways plus a pinned region searched in
// parallel, a registered one-cycle lookup result, refill and flush ports.
// Assumes no duplicate translations and no refill in a flush cycle.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8,
    parameter int SETS   = 32,
    parameter int LOCK_N = 8,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = VPN_W - IDX_W,
    localparam int SLOT_W = $clog2(LOCK_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [1:0]        rsp_perm,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic              rf_global,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [1:0]        rf_perm,
    input  logic              pw_valid,
    input  logic [SLOT_W-1:0] pw_slot,
    input  logic [VPN_W-1:0]  pw_vpn,
    input  logic [ASID_W-1:0] pw_asid,
    input  logic              pw_global,
    input  logic [PFN_W-1:0]  pw_pfn,
    input  logic [1:0]        pw_perm,
    input  logic              fl_all,
    input  logic              fl_asid_en,
    input  logic [ASID_W-1:0] fl_asid
);
    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic [TAG_W-1:0] lk_tag, rf_tag;
    logic [WAYS-1:0]  way_hit, way_wr, way_pv;
    logic [PFN_W-1:0] way_pfn  [WAYS];
    tlb_perm_t        way_perm [WAYS];
    logic             victim, flush_any, main_hit, touch_en;
    logic             lock_hit;
    logic [PFN_W-1:0] lock_pfn;
    tlb_perm_t        lock_perm;

    assign lk_idx    = lk_vpn[IDX_W-1:0];
    assign lk_tag    = lk_vpn[VPN_W-1:IDX_W];
    assign rf_idx    = rf_vpn[IDX_W-1:0];
    assign rf_tag    = rf_vpn[VPN_W-1:IDX_W];
    assign flush_any = fl_all | fl_asid_en;
    assign main_hit  = |way_hit;
    assign touch_en  = lk_req && !flush_any && main_hit;

    // Main-array ways, written only when chosen as the refill victim.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign way_wr[w] = rf_valid && (victim == w[0]);
            tlb_way #(.SETS(SETS), .TAG_W(TAG_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_way (
                .clk(clk), .rst_n(rst_n),
                .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_asid(lk_asid),
                .rd_hit(way_hit[w]), .rd_pfn(way_pfn[w]), .rd_perm(way_perm[w]),
                .wr_en(way_wr[w]), .wr_idx(rf_idx), .wr_tag(rf_tag), .wr_asid(rf_asid),
                .wr_glob(rf_global), .wr_pfn(rf_pfn), .wr_perm(rf_perm),
                .fl_all(fl_all), .fl_asid_en(fl_asid_en), .fl_asid(fl_asid),
                .probe_idx(rf_idx), .probe_valid(way_pv[w])
            );
        end
    endgenerate

    tlb_victim_sel #(.SETS(SETS)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(lk_idx), .touch_way(way_hit[1]),
        .fill_en(rf_valid), .fill_idx(rf_idx),
        .fill_v0(way_pv[0]), .fill_v1(way_pv[1]), .victim(victim)
    );

    tlb_lock_region #(.LOCK_N(LOCK_N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .rd_vpn(lk_vpn), .rd_asid(lk_asid),
        .rd_hit(lock_hit), .rd_pfn(lock_pfn), .rd_perm(lock_perm),
        .wr_en(pw_valid), .wr_slot(pw_slot), .wr_vpn(pw_vpn), .wr_asid(pw_asid),
        .wr_glob(pw_global), .wr_pfn(pw_pfn), .wr_perm(pw_perm)
    );

    // Registered lookup response: pinned entry first, then main array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
            rsp_perm  <= '0;
            if (lk_req && !flush_any) begin
                if (lock_hit) begin
                    rsp_hit  <= 1'b1;
                    rsp_pfn  <= lock_pfn;
                    rsp_perm <= lock_perm;
                end else if (main_hit) begin
                    rsp_hit  <= 1'b1;
                    rsp_pfn  <= way_hit[1] ? way_pfn[1] : way_pfn[0];
                    rsp_perm <= way_hit[1] ? way_perm[1] : way_perm[0];
                end
            end
        end
    end

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    assert_miss_zero_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && rsp_perm == '0));
    assert_flush_lookup_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && flush_any) |=> (rsp_valid && !rsp_hit));
    assert_ways_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));
endmodule

// File: tb/tb_asid_tlb.sv
// Scoreboard bench: driver tasks queue expected lookup results, a monitor
// pops and compares them when the design presents a response.
module tb_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        rsp_valid, rsp_hit;
    logic [19:0] rsp_pfn;
    logic [1:0]  rsp_perm;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic        rf_global = 1'b0;
    logic [19:0] rf_pfn = '0;
    logic [1:0]  rf_perm = '0;
    logic        pw_valid = 1'b0;
    logic [2:0]  pw_slot = '0;
    logic [19:0] pw_vpn = '0;
    logic [7:0]  pw_asid = '0;
    logic        pw_global = 1'b0;
    logic [19:0] pw_pfn = '0;
    logic [1:0]  pw_perm = '0;
    logic        fl_all = 1'b0;
    logic        fl_asid_en = 1'b0;
    logic [7:0]  fl_asid = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        hit;
        logic [19:0] pfn;
        logic [1:0]  perm;
        string       rq;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    asid_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_global(rf_global),
        .rf_pfn(rf_pfn), .rf_perm(rf_perm),
        .pw_valid(pw_valid), .pw_slot(pw_slot), .pw_vpn(pw_vpn), .pw_asid(pw_asid),
        .pw_global(pw_global), .pw_pfn(pw_pfn), .pw_perm(pw_perm),
        .fl_all(fl_all), .fl_asid_en(fl_asid_en), .fl_asid(fl_asid)
    );

    // Monitor: compare each response against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R1: unexpected response hit=%0b pfn=%h, expected none", rsp_hit, rsp_pfn);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_hit !== e.hit || rsp_pfn !== e.pfn || rsp_perm !== e.perm) begin
                    failures++;
                    $display("FAIL %s: got hit=%0b pfn=%h perm=%b, expected hit=%0b pfn=%h perm=%b",
                             e.rq, rsp_hit, rsp_pfn, rsp_perm, e.hit, e.pfn, e.perm);
                end
            end
        end
    end

    task automatic lookup(input logic [19:0] v, input logic [7:0] a, input logic h,
                          input logic [19:0] p, input logic [1:0] pm, input string rq,
                          input logic with_flush = 1'b0);
        exp_t e;
        @(negedge clk);
        e.hit = h; e.pfn = h ? p : 20'h0; e.perm = h ? pm : 2'b00; e.rq = rq;
        sb.push_back(e);
        lk_req = 1'b1; lk_vpn = v; lk_asid = a; fl_all = with_flush;
        @(negedge clk);
        lk_req = 1'b0; fl_all = 1'b0;
    endtask

    task automatic refill(input logic [19:0] v, input logic [7:0] a, input logic g,
                          input logic [19:0] p, input logic [1:0] pm);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = v; rf_asid = a; rf_global = g; rf_pfn = p; rf_perm = pm;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic pin(input logic [2:0] s, input logic [19:0] v, input logic [7:0] a,
                       input logic g, input logic [19:0] p, input logic [1:0] pm);
        @(negedge clk);
        pw_valid = 1'b1; pw_slot = s; pw_vpn = v; pw_asid = a; pw_global = g;
        pw_pfn = p; pw_perm = pm;
        @(negedge clk);
        pw_valid = 1'b0;
    endtask

    task automatic flush_id(input logic [7:0] a);
        @(negedge clk);
        fl_asid_en = 1'b1; fl_asid = a;
        @(negedge clk);
        fl_asid_en = 1'b0;
    endtask

    task automatic flush_everything();
        @(negedge clk);
        fl_all = 1'b1;
        @(negedge clk);
        fl_all = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R12: rsp_valid=%b during reset, expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        lookup(20'h00021, 8'd5, 1'b0, 20'h0, 2'b00, "R12");

        // Identifier matching and global entries.
        refill(20'h00021, 8'd5, 1'b0, 20'hAAAA1, 2'b01);
        lookup(20'h00021, 8'd5, 1'b1, 20'hAAAA1, 2'b01, "R2");
        lookup(20'h00021, 8'd6, 1'b0, 20'h0, 2'b00, "R2");
        lookup(20'h00041, 8'd5, 1'b0, 20'h0, 2'b00, "R2");
        refill(20'h00042, 8'd3, 1'b1, 20'hBBBB2, 2'b10);
        lookup(20'h00042, 8'd9, 1'b1, 20'hBBBB2, 2'b10, "R3");
        lookup(20'h00042, 8'd3, 1'b1, 20'hBBBB2, 2'b10, "R11");

        // Two ways in set 1, then LRU replacement.
        refill(20'h00041, 8'd5, 1'b0, 20'h00C41, 2'b01);
        lookup(20'h00041, 8'd5, 1'b1, 20'h00C41, 2'b01, "R4");
        lookup(20'h00021, 8'd5, 1'b1, 20'hAAAA1, 2'b01, "R4");
        refill(20'h00061, 8'd5, 1'b0, 20'h00C61, 2'b01);
        lookup(20'h00041, 8'd5, 1'b0, 20'h0, 2'b00, "R5");
        lookup(20'h00021, 8'd5, 1'b1, 20'hAAAA1, 2'b01, "R5");
        lookup(20'h00061, 8'd5, 1'b1, 20'h00C61, 2'b01, "R5");
        refill(20'h00081, 8'd5, 1'b0, 20'h00C81, 2'b01);
        lookup(20'h00021, 8'd5, 1'b0, 20'h0, 2'b00, "R5");
        lookup(20'h00061, 8'd5, 1'b1, 20'h00C61, 2'b01, "R5");
        lookup(20'h00081, 8'd5, 1'b1, 20'h00C81, 2'b01, "R5");

        // Pinned region: priority and immunity to refill.
        pin(3'd3, 20'h00081, 8'd5, 1'b0, 20'hD0081, 2'b11);
        lookup(20'h00081, 8'd5, 1'b1, 20'hD0081, 2'b11, "R7");
        pin(3'd0, 20'h12345, 8'd0, 1'b1, 20'h0E0E0, 2'b10);
        lookup(20'h12345, 8'd7, 1'b1, 20'h0E0E0, 2'b10, "R6");
        refill(20'h00005, 8'd1, 1'b0, 20'h00105, 2'b01);
        refill(20'h00025, 8'd1, 1'b0, 20'h00125, 2'b00);
        refill(20'h00045, 8'd1, 1'b0, 20'h00145, 2'b11);
        lookup(20'h12345, 8'd7, 1'b1, 20'h0E0E0, 2'b10, "R6");
        lookup(20'h00005, 8'd1, 1'b0, 20'h0, 2'b00, "R5");
        lookup(20'h00045, 8'd1, 1'b1, 20'h00145, 2'b11, "R11");
        lookup(20'h00025, 8'd1, 1'b1, 20'h00125, 2'b00, "R11");

        // Flush by identifier.
        flush_id(8'd5);
        lookup(20'h00061, 8'd5, 1'b0, 20'h0, 2'b00, "R9");
        lookup(20'h00042, 8'd5, 1'b1, 20'hBBBB2, 2'b10, "R9");
        lookup(20'h00045, 8'd1, 1'b1, 20'h00145, 2'b11, "R9");
        lookup(20'h00081, 8'd5, 1'b1, 20'hD0081, 2'b11, "R9");

        // Lookup during a full flush, then the flushed state.
        lookup(20'h00045, 8'd1, 1'b0, 20'h0, 2'b00, "R10", 1'b1);
        lookup(20'h00045, 8'd1, 1'b0, 20'h0, 2'b00, "R8");
        lookup(20'h00042, 8'd3, 1'b0, 20'h0, 2'b00, "R8");
        flush_everything();
        lookup(20'h12345, 8'd2, 1'b1, 20'h0E0E0, 2'b10, "R8");
        lookup(20'h00081, 8'd5, 1'b1, 20'hD0081, 2'b11, "R8");

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R1: %0d responses missing, expected 0", sb.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule